// File: doc/BRIEF.md
# Instruction Entry Sequencer

This block is the control state machine of a processor debug port. An operator keys an instruction in field by field. When the opcode has been assembled, the sequencer tells the opcode decoder to capture it. It then reads the decoder's category and asks for exactly the operand fields that category needs. For each field it runs a write-then-clear handshake with the temporary field register.

When the last field is in, the sequencer stores the assembled word into program memory at its own 10-bit address, steps the address and resets the entry blocks. The processor is held halted and waiting while the instruction is keyed in. Once the processor is released, the sequencer waits for the processor's busy flag to drop and then reads the result register. The system clock is nominally 10 MHz. Keyboard decoding, the display and the processor lie outside the block.

Top module: `instr_entry_seq`

## Requirements
- R1: While idle, a high `opc_done` sampled at a clock edge makes `latch_dec` high for exactly the next cycle, and `halt` is high from that cycle on.
- R2: The cycle after the latch cycle, `cat` is sampled. Its value selects the fields to request: 0 none, 1 (ALU) Src1+Src2+Target, 2 (branch) Src1+Src2+Imm, 3 (load) Src1+Target+Imm, 4 (store) Src1+Src2+Imm, 5 (PWM) Imm only, 6 and 7 none. Fields are requested in the order Src1, Src2, Target, Imm on `fld_sel` bits 0, 1, 2 and 3, with at most one bit high.
- R3: A field's `fld_sel` bit stays high until `field_done` is sampled high. The next cycle then has a one-cycle `fld_wr`, and the cycle after that has a one-cycle `fld_clr`. The next field's select follows `fld_clr` directly.
- R4: The cycle after the last `fld_clr` (or after the category cycle when no field is needed), `mem_we` is high for one cycle while `prog_addr` shows the current address.
- R5: `mem_we` is followed by a one-cycle `addr_inc`, and that by a one-cycle `int_rst`.
- R6: `prog_addr` is 0 after reset. It steps by one after each `addr_inc` and wraps from 1023 to 0.
- R7: After `int_rst`, the block waits until `proc_busy` is sampled low. The next cycle then raises `res_rd` and `res_en` together for one cycle, and the block returns to idle.
- R8: `halt` is high from the latch cycle through the `mem_we` cycle and low elsewhere. `wait_n` is high only while the block waits for the processor to finish, and it is low whenever `halt` is high.
- R9: Synchronous active-low reset clears every strobe, `halt` and `wait_n`. `opc_done` has no effect outside the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opc_done | input | 1 | Opcode fully keyed in |
| cat | input | 3 | Instruction category from the decoder |
| field_done | input | 1 | Current operand field fully keyed in |
| proc_busy | input | 1 | Processor executing, active high |
| latch_dec | output | 1 | Decoder captures the opcode |
| fld_sel | output | 4 | Field select: bit0 Src1, bit1 Src2, bit2 Target, bit3 Imm |
| fld_wr | output | 1 | Load keyed value into the selected field |
| fld_clr | output | 1 | Empty the temporary latch |
| mem_we | output | 1 | Program memory write |
| addr_inc | output | 1 | Address counter step |
| int_rst | output | 1 | Reset the entry blocks |
| prog_addr | output | 10 | Program memory address |
| res_rd | output | 1 | Result register read |
| res_en | output | 1 | Result register enable |
| halt | output | 1 | Processor halt, active high |
| wait_n | output | 1 | Processor wait, active low |

## Verification
A wrong field mask or a lost pending bit shows up in the first cycle after the category sample or after a clear. Either a wrong `fld_sel` bit lights, or `mem_we` arrives early or late, so the fault is visible at the ports within one handshake. A faulty address counter appears in the `prog_addr` value of the very next `mem_we`, and the run through 1024 writes exposes a wrong wrap. A faulty readback gate shows as `res_rd` high while `proc_busy` is still held high.

// File: rtl/instr_entry_pkg.sv
// Shared types and the category-to-field table of the instruction entry sequencer.
// Assumes a 3-bit category code and four operand fields.
package instr_entry_pkg;

    localparam int NFIELD = 4;   // Src1, Src2, Target, Imm
    localparam int CAT_W  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LATCH,
        ST_CAT,
        ST_FIELD,
        ST_WR,
        ST_CLR,
        ST_MEMWR,
        ST_INCR,
        ST_IRST,
        ST_RUN,
        ST_READ
    } seq_state_t;

    // Field mask per category; bit0 Src1, bit1 Src2, bit2 Target, bit3 Imm.
    function automatic logic [NFIELD-1:0] cat_fields(input logic [CAT_W-1:0] c);
        case (c)
            3'd1:    cat_fields = 4'b0111;
            3'd2:    cat_fields = 4'b1011;
            3'd3:    cat_fields = 4'b1101;
            3'd4:    cat_fields = 4'b1011;
            3'd5:    cat_fields = 4'b1000;
            default: cat_fields = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/field_pick.sv
// Isolates the lowest set bit of a pending-field mask as a one-hot vector.
// Assumes nothing about the input; all-zero input gives all-zero output.
module field_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] pend,
    output logic [N-1:0] first
);
    // Priority chain: a bit wins when no lower bit is pending.
    for (genvar i = 0; i < N; i++) begin : g_pick
        if (i == 0) begin : g_lo
            assign first[i] = pend[i];
        end else begin : g_hi
            assign first[i] = pend[i] & ~|pend[i-1:0];
        end
    end
endmodule

// File: rtl/prog_addr_ctr.sv
// Program memory address counter; steps on a one-cycle increment request.
// Assumes the increment is a single-cycle pulse; wraps naturally at 2**W.
module prog_addr_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] addr
);
    // Hold the address, clear on reset, step on request.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr <= '0;
        else if (inc) addr <= addr + 1'b1;
    end
endmodule

// File: rtl/entry_fsm.sv
// Sequencing state machine: opcode latch, per-field write/clear handshakes,
// memory write, address step, internal reset and result readback.
// Assumes cat is valid the cycle after latch_dec.
module entry_fsm
    import instr_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opc_done,
    input  logic [CAT_W-1:0]  cat,
    input  logic              field_done,
    input  logic              proc_busy,
    output logic              latch_dec,
    output logic [NFIELD-1:0] fld_sel,
    output logic              fld_wr,
    output logic              fld_clr,
    output logic              mem_we,
    output logic              addr_inc,
    output logic              int_rst,
    output logic              res_rd,
    output logic              res_en,
    output logic              halt,
    output logic              wait_n
);
    seq_state_t        state;
    logic [NFIELD-1:0] pending;
    logic [NFIELD-1:0] cur;
    logic [NFIELD-1:0] pick_in;
    logic [NFIELD-1:0] pick_out;

    // Choose which mask feeds the picker: fresh category or what remains.
    always_comb begin
        if (state == ST_CAT) pick_in = cat_fields(cat);
        else                 pick_in = pending & ~cur;
    end

    field_pick #(.N(NFIELD)) u_pick (
        .pend  (pick_in),
        .first (pick_out)
    );

    // State register with pending mask and current-field tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pending <= '0;
            cur     <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (opc_done) state <= ST_LATCH;
                ST_LATCH: state <= ST_CAT;
                ST_CAT, ST_CLR: begin
                    pending <= pick_in;
                    cur     <= pick_out;
                    state   <= (pick_in == '0) ? ST_MEMWR : ST_FIELD;
                end
                ST_FIELD: if (field_done) state <= ST_WR;
                ST_WR:    state <= ST_CLR;
                ST_MEMWR: state <= ST_INCR;
                ST_INCR:  state <= ST_IRST;
                ST_IRST: begin
                    pending <= '0;
                    cur     <= '0;
                    state   <= ST_RUN;
                end
                ST_RUN:   if (!proc_busy) state <= ST_READ;
                ST_READ:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Decode the state into strobes and processor controls.
    always_comb begin
        latch_dec = (state == ST_LATCH);
        fld_sel   = (state == ST_FIELD) ? cur : '0;
        fld_wr    = (state == ST_WR);
        fld_clr   = (state == ST_CLR);
        mem_we    = (state == ST_MEMWR);
        addr_inc  = (state == ST_INCR);
        int_rst   = (state == ST_IRST);
        res_rd    = (state == ST_READ);
        res_en    = (state == ST_READ);
        halt      = (state == ST_LATCH) || (state == ST_CAT) || (state == ST_FIELD)
                 || (state == ST_WR) || (state == ST_CLR) || (state == ST_MEMWR);
        wait_n    = (state == ST_RUN);
    end
endmodule

// File: rtl/instr_entry_seq.sv
// Top of the instruction entry sequencer: control state machine plus the
// program address counter. Assumes a single clock and synchronous reset.
module instr_entry_seq
    import instr_entry_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opc_done,
    input  logic [2:0]        cat,
    input  logic              field_done,
    input  logic              proc_busy,
    output logic              latch_dec,
    output logic [3:0]        fld_sel,
    output logic              fld_wr,
    output logic              fld_clr,
    output logic              mem_we,
    output logic              addr_inc,
    output logic              int_rst,
    output logic [ADDR_W-1:0] prog_addr,
    output logic              res_rd,
    output logic              res_en,
    output logic              halt,
    output logic              wait_n
);
    entry_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .opc_done   (opc_done),
        .cat        (cat),
        .field_done (field_done),
        .proc_busy  (proc_busy),
        .latch_dec  (latch_dec),
        .fld_sel    (fld_sel),
        .fld_wr     (fld_wr),
        .fld_clr    (fld_clr),
        .mem_we     (mem_we),
        .addr_inc   (addr_inc),
        .int_rst    (int_rst),
        .res_rd     (res_rd),
        .res_en     (res_en),
        .halt       (halt),
        .wait_n     (wait_n)
    );

    prog_addr_ctr #(.W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (addr_inc),
        .addr  (prog_addr)
    );
endmodule

// File: rtl/instr_entry_chk.sv
// Protocol checker for the instruction entry sequencer, bound to the top.
module instr_entry_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              opc_done,
    input logic [2:0]        cat,
    input logic              field_done,
    input logic              proc_busy,
    input logic              latch_dec,
    input logic [3:0]        fld_sel,
    input logic              fld_wr,
    input logic              fld_clr,
    input logic              mem_we,
    input logic              addr_inc,
    input logic              int_rst,
    input logic [ADDR_W-1:0] prog_addr,
    input logic              res_rd,
    input logic              res_en,
    input logic              halt,
    input logic              wait_n
);
    AST_LATCH_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) latch_dec |=> !latch_dec); // R1
    AST_LATCH_HALT:   assert property (@(posedge clk) disable iff (!rst_n) latch_dec |-> halt); // R1
    AST_SEL_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fld_sel)); // R2
    AST_SEL_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (|fld_sel && !field_done) |=> $stable(fld_sel)); // R3
    AST_WR_THEN_CLR:  assert property (@(posedge clk) disable iff (!rst_n) fld_wr |=> fld_clr && !fld_wr); // R3
    AST_MEMWR_INC:    assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> addr_inc && !mem_we); // R4
    AST_INC_IRST:     assert property (@(posedge clk) disable iff (!rst_n) addr_inc |=> int_rst); // R5
    AST_ADDR_STEP:    assert property (@(posedge clk) disable iff (!rst_n) addr_inc |=> prog_addr == $past(prog_addr) + 1'b1); // R6
    AST_ADDR_STILL:   assert property (@(posedge clk) disable iff (!rst_n) !addr_inc |=> $stable(prog_addr)); // R6
    AST_READ_PAIR:    assert property (@(posedge clk) disable iff (!rst_n) res_rd |-> res_en); // R7
    AST_READ_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) res_rd |-> !$past(proc_busy)); // R7
    AST_HALT_WAIT:    assert property (@(posedge clk) disable iff (!rst_n) halt |-> !wait_n); // R8
    AST_MEMWR_HALT:   assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> halt); // R8
endmodule

bind instr_entry_seq instr_entry_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/instr_entry_seq_bench.sv
// Sweeps every category, then runs the address counter through its wrap.
module instr_entry_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opc_done = 1'b0;
    logic [2:0] cat = 3'd0;
    logic       field_done = 1'b0;
    logic       proc_busy = 1'b0;
    logic       latch_dec, fld_wr, fld_clr, mem_we, addr_inc, int_rst;
    logic       res_rd, res_en, halt, wait_n;
    logic [3:0] fld_sel;
    logic [9:0] prog_addr;

    int n_chk = 0;
    int n_fail = 0;
    int exp_addr = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    instr_entry_seq u_instr_entry_seq (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected field mask, written from the requirement table (R2).
    function automatic logic [3:0] exp_mask(input logic [2:0] c);
        case (c)
            3'd1: return 4'b0111;
            3'd2: return 4'b1011;
            3'd3: return 4'b1101;
            3'd4: return 4'b1011;
            3'd5: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    // One full entry: latch, fields, memory write, step, reset, readback.
    task automatic enter(input logic [2:0] c, input int hold, input int busy_cyc, input bit poke);
        logic [3:0] m;
        m = exp_mask(c);
        @(negedge clk);
        opc_done = 1'b1;
        cat = c;
        proc_busy = 1'b1;
        @(negedge clk);
        opc_done = 1'b0;
        chk(latch_dec == 1'b1, "R1 latch_dec", int'(latch_dec), 1);
        chk(halt == 1'b1, "R1 halt", int'(halt), 1);
        @(negedge clk);
        chk(latch_dec == 1'b0, "R1 latch single", int'(latch_dec), 0);
        @(negedge clk);
        for (int f = 0; f < 4; f++) begin
            if (m[f]) begin
                for (int h = 0; h < hold; h++) begin
                    chk(fld_sel == 4'(1 << f), "R2 fld_sel", int'(fld_sel), 1 << f);
                    if (poke && h == 0) opc_done = 1'b1;
                    @(negedge clk);
                    opc_done = 1'b0;
                    if (poke && h == 0)
                        chk(latch_dec == 1'b0, "R9 opc_done ignored", int'(latch_dec), 0);
                end
                chk(fld_sel == 4'(1 << f), "R3 held", int'(fld_sel), 1 << f);
                field_done = 1'b1;
                @(negedge clk);
                field_done = 1'b0;
                chk(fld_wr && fld_sel == 4'd0, "R3 fld_wr", int'(fld_wr), 1);
                chk(halt == 1'b1 && wait_n == 1'b0, "R8 halt in entry", int'(halt), 1);
                @(negedge clk);
                chk(fld_clr && !fld_wr, "R3 fld_clr", int'(fld_clr), 1);
                @(negedge clk);
            end
        end
        chk(mem_we == 1'b1, "R4 mem_we", int'(mem_we), 1);
        chk(int'(prog_addr) == exp_addr, "R4 addr at write", int'(prog_addr), exp_addr);
        chk(halt == 1'b1, "R8 halt at write", int'(halt), 1);
        @(negedge clk);
        chk(addr_inc && !mem_we, "R5 addr_inc", int'(addr_inc), 1);
        chk(halt == 1'b0, "R8 halt released", int'(halt), 0);
        @(negedge clk);
        exp_addr = (exp_addr + 1) % 1024;
        chk(int_rst == 1'b1, "R5 int_rst", int'(int_rst), 1);
        chk(int'(prog_addr) == exp_addr, "R6 addr step", int'(prog_addr), exp_addr);
        @(negedge clk);
        for (int b = 0; b < busy_cyc; b++) begin
            chk(wait_n && !res_rd, "R7 waiting on busy", int'(res_rd), 0);
            @(negedge clk);
        end
        proc_busy = 1'b0;
        chk(wait_n == 1'b1, "R8 wait_n released", int'(wait_n), 1);
        @(negedge clk);
        chk(res_rd && res_en, "R7 readback", int'(res_rd), 1);
        @(negedge clk);
        chk(!res_rd && !wait_n && !halt, "R7 back to idle", int'(res_rd), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!latch_dec && fld_sel == 4'd0 && !mem_we && !halt && !wait_n && !res_rd,
            "R9 reset state", int'(halt), 0);
        chk(prog_addr == 10'd0, "R6 reset addr", int'(prog_addr), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++)
            for (int h = 1; h <= 3; h++)
                enter(3'(c), h, h, (h == 2));
        while (exp_addr != 1023) enter(3'd0, 1, 0, 1'b0);
        enter(3'd5, 1, 1, 1'b0);
        chk(prog_addr == 10'd0, "R6 wrap to zero", int'(prog_addr), 0);
        enter(3'd1, 2, 0, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule